// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the processor-facing side of a byte-oriented serial port. A bus master reaches it through single-cycle 32-bit word accesses. Behind the register window, outgoing bytes leave through a valid/ready byte port toward a transmitter. Incoming bytes arrive through a second valid/ready port and collect in a small circular receive queue until software reads them.

Software can look at the head of the receive queue without disturbing it, or read it and remove it in one access. A raw interrupt word collects transmit-done and receive-pending causes. Software clears causes by writing ones to an acknowledge word. A mask word selects which raw causes drive the single level-sensitive interrupt line.

A byte written for transmission is never lost. If the transmitter cannot take it, the bus access is held until the transmitter can.

Top module: `sreg_front`

## Requirements
- R1: After reset, receive control (word index 2) reads 0x00010000, raw interrupt (word index 13) reads 0, `rx_ready` is low and `irq` is low.
- R2: Word indices 0 (transmit control), 1 (transmit DMA enable) and 11 (interrupt mask) are plain 32-bit storage. A write is returned unchanged by a later read.
- R3: Word indices 3, 4, 5, 6, 10 and 15 read as 0. Writes to them change nothing that can be read back.
- R4: A read of word index 8 (peek) or word index 9 (pop) returns 0x01400000, which has bit 24 (transmitter ready) and bit 22 (transmitter idle) set. It ORs in the oldest queued byte in bits 7:0, or 0 there when the queue is empty.
- R5: A read of word index 9 removes the oldest byte when the queue is not empty. A read of word index 8 leaves the queue unchanged.
- R6: The receive queue holds RX_DEPTH (default 16) bytes and returns them in arrival order. A byte accepted while the queue is full is discarded.
- R7: `rx_ready` equals bit 3 of the receive control word. No byte is taken while it is low.
- R8: A write to word index 7 (data out) presents bits 7:0 on `tx_data` with `tx_valid` high, sets raw interrupt bits 0 and 1, and stores the word for read-back.
- R9: While a data-out write is pending and `tx_ready` is low, `bus_ready` stays low and no register changes. The access completes in the cycle `tx_ready` is high.
- R10: A write to word index 12 (acknowledge) stores the value for read-back and clears every raw interrupt bit that is 1 in the written value.
- R11: Raw interrupt bit 3 is 1 exactly when the receive queue is non-empty. It is updated on the same clock edge as the queue occupancy, and acknowledge cannot clear it while bytes remain.
- R12: Word index 14 reads raw AND mask. `irq` is high exactly when that masked value is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes this cycle |
| bus_rdata | output | 32 | Read data, valid while bus_req and bus_ready |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Receiver enabled |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with the default RX_DEPTH of 16. This keeps the queue small enough to fill past capacity with seventeen bytes and then drain completely. That run exercises the drop rule, pointer wrap-around, and the empty-read value that follows. The small depth also lets the pending-byte interrupt be driven through both edges (empty to non-empty and back) within a short run. Interleaved peeks and pops around those edges show that only the pop view moves the queue.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int WIDX_W = 4;
    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;

    // word indices; software relies on these positions
    localparam logic [WIDX_W-1:0] W_TXCTRL = 4'h0;
    localparam logic [WIDX_W-1:0] W_TXDMA  = 4'h1;
    localparam logic [WIDX_W-1:0] W_RXCTRL = 4'h2;
    localparam logic [WIDX_W-1:0] W_DOUT   = 4'h7;
    localparam logic [WIDX_W-1:0] W_PEEK   = 4'h8;
    localparam logic [WIDX_W-1:0] W_POP    = 4'h9;
    localparam logic [WIDX_W-1:0] W_MASK   = 4'hB;
    localparam logic [WIDX_W-1:0] W_ACK    = 4'hC;
    localparam logic [WIDX_W-1:0] W_RAW    = 4'hD;
    localparam logic [WIDX_W-1:0] W_MASKED = 4'hE;

    localparam int TX_READY_BIT = 24;
    localparam int TX_IDLE_BIT  = 22;
    localparam int RX_EN_BIT    = 3;
    localparam int RAW_RXNE_BIT = 3;

    localparam logic [REG_W-1:0] RXCTRL_RESET = 32'h0001_0000;
    localparam logic [REG_W-1:0] TX_RAW_BITS  = 32'h0000_0003;
    localparam logic [REG_W-1:0] STATUS_BASE  =
        (REG_W'(1) << TX_READY_BIT) | (REG_W'(1) << TX_IDLE_BIT);

    typedef struct packed {
        logic [REG_W-1:0] txctrl;
        logic [REG_W-1:0] txdma;
        logic [REG_W-1:0] rxctrl;
        logic [REG_W-1:0] dout;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] ack;
    } ctl_regs_t;

    typedef struct packed {
        logic             set_tx;
        logic             ack_en;
        logic [REG_W-1:0] wdata;
    } irq_evt_t;

    function automatic ctl_regs_t ctl_reset_val();
        ctl_regs_t r;
        r        = '0;
        r.rxctrl = RXCTRL_RESET;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] status_word(input logic empty,
                                                     input logic [BYTE_W-1:0] head);
        return STATUS_BASE | {{(REG_W-BYTE_W){1'b0}}, (empty ? '0 : head)};
    endfunction
endpackage

// File: rtl/sreg_rxfifo.sv
module sreg_rxfifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              nonempty_nxt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic              do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (cnt_q != FULL);   // full: byte discarded
    assign head    = empty ? '0 : mem[rd_q];

    always_comb begin
        case ({do_push, do_pop})
            2'b10:   cnt_nxt = cnt_q + ONE;
            2'b01:   cnt_nxt = cnt_q - ONE;
            default: cnt_nxt = cnt_q;
        endcase
    end
    assign nonempty_nxt = (cnt_nxt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (do_push) wr_q <= wr_q + PTR_W'(1);
            if (do_pop)  rd_q <= rd_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end
endmodule

// File: rtl/sreg_irq.sv
module sreg_irq
    import sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  irq_evt_t         evt,
    input  logic             rx_nonempty_nxt,
    input  logic [REG_W-1:0] mask,
    output logic [REG_W-1:0] raw,
    output logic [REG_W-1:0] masked,
    output logic             irq
);
    logic [REG_W-1:0] raw_q, raw_nxt;

    always_comb begin
        raw_nxt = raw_q;
        if (evt.set_tx) raw_nxt = raw_nxt | TX_RAW_BITS;
        if (evt.ack_en) raw_nxt = raw_nxt & ~evt.wdata;
        raw_nxt[RAW_RXNE_BIT] = rx_nonempty_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= raw_nxt;
    end

    assign raw    = raw_q;
    assign masked = raw_q & mask;
    assign irq    = |masked;
endmodule

// File: rtl/sreg_front.sv
module sreg_front
    import sreg_pkg::*;
#(
    parameter int RX_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [WIDX_W-1:0] bus_widx,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic              bus_ready,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              irq
);
    ctl_regs_t         ctl_q;
    irq_evt_t          evt;
    logic              wr_acc, rd_acc, pop_rd;
    logic [BYTE_W-1:0] head;
    logic              fifo_empty, nonempty_nxt;
    logic [REG_W-1:0]  raw_w, masked_w;

    // outgoing byte goes straight from the bus; the access waits for the taker
    assign tx_valid  = bus_req && bus_wr && (bus_widx == W_DOUT);
    assign tx_data   = bus_wdata[BYTE_W-1:0];
    assign bus_ready = !tx_valid || tx_ready;
    assign wr_acc    = bus_req && bus_ready && bus_wr;
    assign rd_acc    = bus_req && bus_ready && !bus_wr;
    assign pop_rd    = rd_acc && (bus_widx == W_POP);
    assign rx_ready  = ctl_q.rxctrl[RX_EN_BIT];

    assign evt.set_tx = wr_acc && (bus_widx == W_DOUT);
    assign evt.ack_en = wr_acc && (bus_widx == W_ACK);
    assign evt.wdata  = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= ctl_reset_val();
        end else if (wr_acc) begin
            case (bus_widx)
                W_TXCTRL: ctl_q.txctrl <= bus_wdata;
                W_TXDMA:  ctl_q.txdma  <= bus_wdata;
                W_RXCTRL: ctl_q.rxctrl <= bus_wdata;
                W_DOUT:   ctl_q.dout   <= bus_wdata;
                W_MASK:   ctl_q.mask   <= bus_wdata;
                W_ACK:    ctl_q.ack    <= bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (bus_widx)
            W_TXCTRL: bus_rdata = ctl_q.txctrl;
            W_TXDMA:  bus_rdata = ctl_q.txdma;
            W_RXCTRL: bus_rdata = ctl_q.rxctrl;
            W_DOUT:   bus_rdata = ctl_q.dout;
            W_PEEK,
            W_POP:    bus_rdata = status_word(fifo_empty, head);
            W_MASK:   bus_rdata = ctl_q.mask;
            W_ACK:    bus_rdata = ctl_q.ack;
            W_RAW:    bus_rdata = raw_w;
            W_MASKED: bus_rdata = masked_w;
            default:  bus_rdata = '0;
        endcase
    end

    sreg_rxfifo #(.DEPTH(RX_DEPTH), .DATA_W(BYTE_W)) u_fifo (
        .clk          (clk),
        .rst          (rst),
        .push         (rx_valid && rx_ready),
        .push_data    (rx_data),
        .pop          (pop_rd),
        .head         (head),
        .empty        (fifo_empty),
        .nonempty_nxt (nonempty_nxt)
    );

    sreg_irq u_irq (
        .clk             (clk),
        .rst             (rst),
        .evt             (evt),
        .rx_nonempty_nxt (nonempty_nxt),
        .mask            (ctl_q.mask),
        .raw             (raw_w),
        .masked          (masked_w),
        .irq             (irq)
    );
endmodule

// File: rtl/sreg_front_chk.sv
module sreg_front_chk
    import sreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [WIDX_W-1:0] bus_widx,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              bus_ready,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_ready,
    input logic [REG_W-1:0]  raw,
    input logic              fifo_empty
);
    // R4
    data_in_status_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_wr && (bus_widx == W_PEEK || bus_widx == W_POP))
        |-> (bus_rdata[TX_READY_BIT] && bus_rdata[TX_IDLE_BIT]));

    // R4
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_wr && bus_widx == W_POP && fifo_empty)
        |-> (bus_rdata[BYTE_W-1:0] == '0));

    // R3
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_wr && (bus_widx inside {4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hF}))
        |-> (bus_rdata == '0));

    // R7
    rx_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ready && bus_wr && bus_widx == W_RXCTRL)
        |=> (rx_ready == $past(bus_wdata[RX_EN_BIT])));

    // R8
    tx_raw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ready && bus_wr && bus_widx == W_DOUT)
        |=> (raw[1:0] == 2'b11));

    // R9
    tx_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |-> !bus_ready);

    // R11
    rxne_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        raw[RAW_RXNE_BIT] == !fifo_empty);
endmodule

bind sreg_front sreg_front_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_widx   (bus_widx),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .bus_rdata  (bus_rdata),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_ready   (rx_ready),
    .raw        (raw_w),
    .fifo_empty (fifo_empty)
);

// File: tb/tb_sreg_front.sv
module tb_sreg_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_widx = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        irq;

    always #2.5 clk = ~clk;

    sreg_front dut (.*);

    int checks = 0, errors = 0;
    bit mon_on = 0;

    // behavioural reference model
    logic [7:0]  q[$];
    logic [7:0]  txlog[$];
    logic [31:0] m_txctrl = 0, m_dma = 0, m_rxctrl = 32'h0001_0000;
    logic [31:0] m_dout = 0, m_mask = 0, m_ack = 0, m_raw = 0;

    function automatic logic [31:0] raw_full();
        return m_raw | ((q.size() != 0) ? 32'h8 : 32'h0);
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] w);
        case (w)
            4'h0: return m_txctrl;
            4'h1: return m_dma;
            4'h2: return m_rxctrl;
            4'h7: return m_dout;
            4'h8, 4'h9: return 32'h0140_0000 | ((q.size() != 0) ? {24'h0, q[0]} : 32'h0);
            4'hB: return m_mask;
            4'hC: return m_ack;
            4'hD: return raw_full();
            4'hE: return raw_full() & m_mask;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] w, input string tag);
        @(negedge clk);
        bus_req = 1; bus_wr = 0; bus_widx = w;
        #1 chk(tag, bus_rdata, exp_read(w));
        @(posedge clk);
        #1 bus_req = 0;
        if (w == 4'h9 && q.size() != 0) void'(q.pop_front());
    endtask

    task automatic wr(input logic [3:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_widx = w; bus_wdata = d;
        #1;
        while (!bus_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 bus_req = 0; bus_wr = 0;
        case (w)
            4'h0: m_txctrl = d;
            4'h1: m_dma    = d;
            4'h2: m_rxctrl = d;
            4'h7: begin m_dout = d; m_raw = m_raw | 32'h3; end
            4'hB: m_mask   = d;
            4'hC: begin m_ack = d; m_raw = m_raw & ~d; end
            default: ;
        endcase
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_data = b;
        @(posedge clk);
        #1 rx_valid = 0;
        if (m_rxctrl[3] && q.size() < 16) q.push_back(b);
    endtask

    // per-clock comparison of level outputs
    always @(negedge clk) if (mon_on) begin
        chk("R12 irq level", {31'h0, irq}, {31'h0, |(raw_full() & m_mask)});
        chk("R7 rx_ready", {31'h0, rx_ready}, {31'h0, m_rxctrl[3]});
    end

    always @(posedge clk) if (!rst && tx_valid && tx_ready) txlog.push_back(tx_data);

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        mon_on = 1;

        // R1 reset values, checked against constants
        @(negedge clk);
        bus_req = 1; bus_wr = 0; bus_widx = 4'h2;
        #1 chk("R1 rxctrl reset", bus_rdata, 32'h0001_0000);
        bus_widx = 4'hD;
        #1 chk("R1 raw reset", bus_rdata, 32'h0);
        chk("R1 rx_ready/irq", {30'h0, rx_ready, irq}, 32'h0);
        @(posedge clk); #1 bus_req = 0;

        // R2 plain storage
        wr(4'h0, 32'hA5A5_0001); rd(4'h0, "R2 txctrl");
        wr(4'h1, 32'h0000_0001); rd(4'h1, "R2 dma");
        wr(4'hB, 32'h0000_0000); rd(4'hB, "R2 mask");

        // R3 unmapped
        wr(4'h5, 32'hFFFF_FFFF); rd(4'h5, "R3 idx5");
        wr(4'hA, 32'h1234_5678); rd(4'hA, "R3 idx10");
        rd(4'hF, "R3 idx15"); rd(4'h3, "R3 idx3");
        rd(4'h0, "R3 txctrl untouched");

        // R7 receiver gated off
        push(8'h55);
        rd(4'h8, "R7 byte refused, R4 empty peek");
        wr(4'h2, 32'h0001_0008);
        rd(4'h2, "R7 rxctrl");

        // R6 fill past capacity, R11 raw pending bit
        for (int i = 0; i < 17; i++) push(8'h10 + 8'(i));
        rd(4'hD, "R11 raw with pending");
        rd(4'h8, "R5 peek first");
        rd(4'h8, "R5 peek again unchanged");
        for (int i = 0; i < 16; i++) rd(4'h9, "R6 pop order");
        rd(4'h9, "R4 pop empty");
        rd(4'hD, "R11 raw after drain");

        // R8 data out
        wr(4'h7, 32'h1234_56C3);
        chk("R8 tx byte count", txlog.size(), 1);
        if (txlog.size() != 0) chk("R8 tx byte", {24'h0, txlog[0]}, 32'hC3);
        rd(4'h7, "R8 dout readback");
        rd(4'hD, "R8 raw bits");

        // R12 mask
        wr(4'hB, 32'h2);
        rd(4'hE, "R12 masked");

        // R10 acknowledge
        wr(4'hC, 32'h1);
        rd(4'hD, "R10 raw after ack");
        rd(4'hC, "R10 ack readback");
        wr(4'hC, 32'h2);
        rd(4'hE, "R10 masked cleared");

        // R11 pending bit drives irq, ack cannot clear it
        wr(4'hB, 32'h8);
        push(8'hE7);
        wr(4'hC, 32'h8);
        rd(4'hD, "R11 ack ignored while pending");
        rd(4'h9, "R11 pop last");
        rd(4'hD, "R11 raw cleared");

        // R9 stall
        tx_ready = 0;
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_widx = 4'h7; bus_wdata = 32'h0000_0042;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R9 stalled ready", {31'h0, bus_ready}, 32'h0);
            chk("R9 tx_valid held", {31'h0, tx_valid}, 32'h1);
            chk("R9 raw unchanged", {31'h0, irq}, 32'h0);
            @(negedge clk);
        end
        tx_ready = 1;
        #1 chk("R9 released", {31'h0, bus_ready}, 32'h1);
        @(posedge clk);
        #1 bus_req = 0; bus_wr = 0;
        m_dout = 32'h42; m_raw = m_raw | 32'h3;
        chk("R9 one byte sent", txlog.size(), 2);
        if (txlog.size() == 2) chk("R9 byte value", {24'h0, txlog[1]}, 32'h42);
        rd(4'hD, "R9 raw after send");

        // R5 peek/pop mix
        push(8'h61); push(8'h62);
        rd(4'h9, "R5 pop one");
        rd(4'h8, "R5 peek second");
        rd(4'h9, "R5 pop second");
        rd(4'h8, "R5 peek empty");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule